// File: doc/BRIEF.md
# Double-Buffered DAC Bus Front End

This block is the digital front end of a 14-bit multiplying converter that hangs on an 8-bit processor data bus. A write is accepted when the active-low select and the active-low write strobe are both low; two address bits then pick what happens on that clock edge. The upper 6 bits and the lower 8 bits of a code are staged in two separate input registers by two writes. A third write copies both halves into the converter register together, so the analog output never shows a half-updated code.

A direct-load address makes every register transparent for one write. The bus byte fills the lower 8 bits of the code and its low 6 bits fill the upper part. Both input registers take the same value, so an all-zeros or all-ones byte sets zero or full scale in one write. A flag marks the offset-binary mid-scale code, which is the zero-output point in bipolar use.

Top module: `dac_bus_front`

## Requirements
- R1: While `rst_n` is low, every register is cleared: `dac_code` is 0 and `mid_scale` is 0. A transfer (address 2'b11) issued right after reset loads 0, because both input registers are also cleared.
- R2: While `cs_n` is high, no register changes at a clock edge, whatever the other inputs are.
- R3: While `wr_n` is high, no register changes at a clock edge, whatever the address.
- R4: With `cs_n` and `wr_n` both low and `addr` = 2'b00, after the edge `dac_code` = {`bus[5:0]`, `bus[7:0]`}. The upper input register takes `bus[5:0]` and the lower one takes `bus[7:0]`.
- R5: An accepted write with `addr` = 2'b01 loads only the upper input register, from `bus[5:0]`. `bus[7:6]` are ignored and `dac_code` is unchanged.
- R6: An accepted write with `addr` = 2'b10 loads only the lower input register, from `bus[7:0]`. `dac_code` is unchanged.
- R7: An accepted write with `addr` = 2'b11 loads `dac_code` with {upper register, lower register} as they stood before that edge. Both halves change on the same edge.
- R8: `mid_scale` is 1 exactly when `dac_code` equals 14'h2000.
- R9: A direct load of bus 8'h00 gives `dac_code` 14'h0000, and a direct load of 8'hFF gives 14'h3FFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; registers update on its rising edge |
| rst_n | input | 1 | Active-low reset, clears all registers |
| cs_n | input | 1 | Active-low device select |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Operation select: 00 direct, 01 upper, 10 lower, 11 transfer |
| bus | input | 8 | Processor data bus |
| dac_code | output | 14 | Converter register value |
| mid_scale | output | 1 | High when the code is the offset-binary mid-scale value |

## Verification
On every cycle, the assertions check several rules. A deselected or unstrobed cycle leaves all three registers unchanged. A staging write touches only its own half and leaves the converter register alone. A direct load and a transfer each produce the expected code on the next edge. Only the bench's sequences can show a full staged update end to end: the value a transfer picks up after earlier blocked writes, reaching mid-scale through staging, the zero and full-scale shortcuts, and reset in the middle of an operation.

// File: rtl/dac_bus_front.sv
module dac_bus_front #(
  parameter int BUS_W  = 8,
  parameter int CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [BUS_W-1:0]  bus,
  output logic [CODE_W-1:0] dac_code,
  output logic              mid_scale
);
  localparam int HI_W = CODE_W - BUS_W;
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic [HI_W-1:0]   hi_q;
  logic [BUS_W-1:0]  lo_q;
  logic [CODE_W-1:0] dac_q;
  logic              wr_ok;

  assign wr_ok = ~cs_n & ~wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      dac_q <= '0;
    end else if (wr_ok) begin
      case (addr)
        2'b00: begin
          hi_q  <= bus[HI_W-1:0];
          lo_q  <= bus;
          dac_q <= {bus[HI_W-1:0], bus};
        end
        2'b01: hi_q <= bus[HI_W-1:0];
        2'b10: lo_q <= bus;
        default: dac_q <= {hi_q, lo_q};
      endcase
    end
  end

  assign dac_code  = dac_q;
  assign mid_scale = (dac_q == MID);

  // R2
  deselect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(dac_q) && $stable(hi_q) && $stable(lo_q)));

  // R3
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> ($stable(dac_q) && $stable(hi_q) && $stable(lo_q)));

  // R4
  direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == 2'b00) |=>
      (dac_code == {$past(bus[HI_W-1:0]), $past(bus)}));

  // R5
  upper_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == 2'b01) |=> ($stable(dac_q) && $stable(lo_q)));

  // R6
  lower_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == 2'b10) |=> ($stable(dac_q) && $stable(hi_q)));

  // R7
  transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == 2'b11) |=> (dac_code == {$past(hi_q), $past(lo_q)}));
endmodule

// File: tb/dac_bus_front_tb.sv
`timescale 1ns/1ps
module dac_bus_front_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic wr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] bus = 8'h00;
  logic [13:0] dac_code;
  logic mid_scale;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dac_bus_front u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
    .addr(addr), .bus(bus), .dac_code(dac_code), .mid_scale(mid_scale)
  );

  // {cs_n, wr_n, addr, bus, expected code, expected flag}
  localparam int NV = 18;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'b01, 8'h2A, 14'h0000, 1'b0},
    {1'b0, 1'b0, 2'b10, 8'h5C, 14'h0000, 1'b0},
    {1'b0, 1'b0, 2'b11, 8'h00, 14'h2A5C, 1'b0},
    {1'b1, 1'b0, 2'b01, 8'hFF, 14'h2A5C, 1'b0},
    {1'b0, 1'b0, 2'b11, 8'h33, 14'h2A5C, 1'b0},
    {1'b0, 1'b1, 2'b10, 8'h00, 14'h2A5C, 1'b0},
    {1'b0, 1'b0, 2'b11, 8'h00, 14'h2A5C, 1'b0},
    {1'b0, 1'b0, 2'b00, 8'hFF, 14'h3FFF, 1'b0},
    {1'b0, 1'b0, 2'b11, 8'h00, 14'h3FFF, 1'b0},
    {1'b0, 1'b0, 2'b01, 8'h20, 14'h3FFF, 1'b0},
    {1'b0, 1'b0, 2'b10, 8'h00, 14'h3FFF, 1'b0},
    {1'b0, 1'b0, 2'b11, 8'h00, 14'h2000, 1'b1},
    {1'b0, 1'b0, 2'b00, 8'h00, 14'h0000, 1'b0},
    {1'b0, 1'b0, 2'b00, 8'hA7, 14'h27A7, 1'b0},
    {1'b0, 1'b0, 2'b01, 8'hE0, 14'h27A7, 1'b0},
    {1'b0, 1'b0, 2'b11, 8'h00, 14'h20A7, 1'b0},
    {1'b0, 1'b0, 2'b10, 8'h00, 14'h20A7, 1'b0},
    {1'b0, 1'b0, 2'b11, 8'h00, 14'h2000, 1'b1}
  };

  function automatic string tag_of(logic c, logic w, logic [1:0] a);
    if (c) return "R2";
    if (w) return "R3";
    case (a)
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [13:0] got, logic [13:0] exp, logic gm, logic em);
    checks++;
    if (got !== exp || gm !== em) begin
      fails++;
      $display("FAIL %s: code=%h flag=%b expected code=%h flag=%b", req, got, gm, exp, em);
    end
  endtask

  task automatic cycle(logic c, logic w, logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cs_n = c; wr_n = w; addr = a; bus = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", dac_code, 14'h0000, mid_scale, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i][26], VEC[i][25], VEC[i][24:23], VEC[i][22:15]);
      check(tag_of(VEC[i][26], VEC[i][25], VEC[i][24:23]), dac_code, VEC[i][14:1], mid_scale, VEC[i][0]);
    end
    // R8: mid-scale flag asserted from the table's last step, now cleared by direct load
    cycle(1'b0, 1'b0, 2'b00, 8'h01);
    check("R8 flag off", dac_code, 14'h0101, mid_scale, 1'b0);
    // R9: zero and full scale in one write each
    cycle(1'b0, 1'b0, 2'b00, 8'hFF);
    check("R9 full", dac_code, 14'h3FFF, mid_scale, 1'b0);
    cycle(1'b0, 1'b0, 2'b00, 8'h00);
    check("R9 zero", dac_code, 14'h0000, mid_scale, 1'b0);
    // R1: reset in the middle of staging clears input registers too
    cycle(1'b0, 1'b0, 2'b01, 8'h15);
    cycle(1'b0, 1'b0, 2'b10, 8'h77);
    cycle(1'b0, 1'b0, 2'b11, 8'h00);
    check("R7 pre-reset", dac_code, 14'h1577, mid_scale, 1'b0);
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    rst_n = 1'b0;
    #1;
    check("R1 async clear", dac_code, 14'h0000, mid_scale, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    cycle(1'b0, 1'b0, 2'b11, 8'hFF);
    check("R1 cleared inputs", dac_code, 14'h0000, mid_scale, 1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule